// File: doc/BRIEF.md
# Serial Receive Character Queue

This block takes characters from a serial deserializer and holds them until software reads them. Each character comes in as a one-cycle valid strobe with its data and a parity-error bit. Storage has three layers. A four-stage first-in first-out queue sits at the read side. In front of it is a single holding buffer, and in front of that is a stage that stands for the character still held in the shift register. A character that arrives while the queue has room goes straight into the queue. When the queue is full, the character waits in the buffer and then in the shift stage, and it moves forward as soon as a read frees a slot.

Software starts reception with a one-cycle enable pulse. It programs a fill level at which a one-cycle receive interrupt fires. A limit option makes the usable queue depth equal to that fill level. A stop option makes the block drop its own receive enable once the queue, the buffer and the shift stage all hold data. Without the stop option, reception continues while software drains the queue. A character that finds every layer occupied in that case is lost and raises a sticky overrun flag. A clear pulse empties the queue, drops the overrun flag and re-arms the interrupt.

Top module: `rx_char_queue`

## Requirements
- R1: After reset, the queue count is 0 and the receive enable, buffer-full flag, overrun flag, interrupt, read data and read parity are all 0.
- R2: A pulse on `rxEnSet` sets `rxEn` on the next edge. While `rxEn` is 0, strobed characters are ignored and the count does not change.
- R3: A character that arrives while the buffer is empty and the queue has room is in the queue after the next edge. The count rises by one and `bufFull` stays 0.
- R4: A read strobe removes the oldest entry. Its data and its own parity-error bit appear on `rdData`/`rdParErr` after the next edge, and they hold there until the next read. The count falls by one unless a push lands on the same edge.
- R5: A read strobe while the queue is empty drives `rdData` and `rdParErr` to 0 after the next edge and leaves the count unchanged.
- R6: `fillLevel` is 2 bits wide, with 0 meaning 4 entries and 1 to 3 meaning that many entries. `rxIrq` is high for exactly one cycle, on the first cycle the count is at or above the level. It fires again only after the count has dropped below the level and then risen back to it.
- R7: With `limitToLevel` set, the queue accepts no more than the fill level. Further characters go to the buffer (`bufFull`=1) and then to the shift stage.
- R8: With `stopAtFull` set, `rxEn` falls on the same edge that leaves the queue at its usable depth with both the buffer and the shift stage occupied. Characters after that are ignored and do not set overrun.
- R9: A read moves the buffered character into the queue on the same edge, and the shift-stage character moves into the buffer. Without `stopAtFull`, `rxEn` stays 1 throughout.
- R10: A character that arrives with `rxEn` = 1 while the queue, the buffer and the shift stage are all full is discarded and sets `overrun`. `overrun` stays set until a `fifoClr` pulse.
- R11: A `fifoClr` pulse empties the queue and re-arms the interrupt. Characters in the buffer and the shift stage are kept and move into the queue on the following cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| charValid | input | 1 | One-cycle strobe: a character is complete |
| charData | input | DATA_W | Character data |
| charParErr | input | 1 | Parity error seen on this character |
| rxEnSet | input | 1 | Pulse that sets receive enable |
| fifoClr | input | 1 | Pulse that empties the queue |
| fillLevel | input | 2 | Interrupt fill level, 0 means 4 |
| limitToLevel | input | 1 | Usable depth equals fill level |
| stopAtFull | input | 1 | Drop receive enable when every layer is full |
| rdStrobe | input | 1 | Pop the oldest entry |
| rdData | output | DATA_W | Data of the last popped entry |
| rdParErr | output | 1 | Parity-error bit of the last popped entry |
| fifoCount | output | 3 | Entries in the queue |
| bufFull | output | 1 | Holding buffer occupied |
| rxEn | output | 1 | Receive enable |
| overrun | output | 1 | Sticky character-lost flag |
| rxIrq | output | 1 | One-cycle fill-level interrupt |

## Verification
The bench pops and pushes on the same edge. A write index that ignored the pop would overwrite or skip an entry, and the data read back would come out of order. It backs the queue up into the buffer and the shift stage, then drains it. A design that lost the shift-stage character, or failed to advance the buffer on a read, would return a gap or a zero where data is expected. The bench also lowers the count under the fill level and raises it again, and it clears the queue with the buffer occupied. A latched or level-style interrupt would then show a wide pulse or no second pulse. It also pushes into a fully occupied design in both modes. A design that dropped the enable too early or too late would accept a character that should be lost, or lose one that should be kept, and the overrun flag would then disagree.

// File: rtl/rxq_pkg.sv
package rxq_pkg;

  // Strobes from the control block to the storage datapath
  typedef struct packed {
    logic push;          // write one entry into the queue
    logic pushFromBuf;   // written entry comes from the holding buffer
    logic pop;           // remove the head entry
    logic clr;           // empty the queue
    logic bufLoad;       // load the holding buffer
    logic bufFromShift;  // buffer loads from the shift stage, else from the arrival
    logic shiftLoad;     // load the shift stage from the arrival
    logic rdZero;        // read found nothing: return zero
  } rxq_strobe_t;

endpackage

// File: rtl/rxq_ctrl.sv
module rxq_ctrl
  import rxq_pkg::*;
#(
  parameter int unsigned DEPTH = 4,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1),
  localparam int unsigned IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             charValid,
  input  logic             rxEnSet,
  input  logic             fifoClr,
  input  logic             rdStrobe,
  input  logic             limitToLevel,
  input  logic             stopAtFull,
  input  logic [IDX_W-1:0] fillLevel,
  output rxq_strobe_t      stb,
  output logic [IDX_W-1:0] wrIdx,
  output logic [CNT_W-1:0] count,
  output logic             bufFull,
  output logic             rxEn,
  output logic             overrun,
  output logic             rxIrq
);

  logic [CNT_W-1:0] level, cap, effCount, nextCount;
  logic accept, doPop, space, moveBuf, direct, drop;
  logic shiftFull, nextBuf, nextShift, nextAllFull, wasAbove, atLevel;

  always_comb begin
    level     = (fillLevel == '0) ? CNT_W'(DEPTH) : CNT_W'(fillLevel);
    cap       = limitToLevel ? level : CNT_W'(DEPTH);
    accept    = charValid && rxEn;
    doPop     = rdStrobe && (count != '0) && !fifoClr;
    effCount  = count - CNT_W'(doPop);
    space     = !fifoClr && (effCount < cap);
    moveBuf   = bufFull && space;
    direct    = accept && !bufFull && space;
    drop      = accept && bufFull && shiftFull && !moveBuf;

    stb             = '0;
    stb.clr         = fifoClr;
    stb.pop         = doPop;
    stb.rdZero      = rdStrobe && !doPop;
    stb.push        = moveBuf || direct;
    stb.pushFromBuf = moveBuf;

    nextBuf   = bufFull;
    nextShift = shiftFull;
    if (moveBuf) begin
      if (shiftFull) begin
        stb.bufLoad      = 1'b1;
        stb.bufFromShift = 1'b1;
        if (accept) stb.shiftLoad = 1'b1;
        else        nextShift     = 1'b0;
      end else if (accept) begin
        stb.bufLoad = 1'b1;
      end else begin
        nextBuf = 1'b0;
      end
    end else if (!bufFull) begin
      if (accept && !direct) begin
        stb.bufLoad = 1'b1;
        nextBuf     = 1'b1;
      end
    end else if (accept && !shiftFull) begin
      stb.shiftLoad = 1'b1;
      nextShift     = 1'b1;
    end

    nextCount   = fifoClr ? '0 : effCount + CNT_W'(stb.push);
    nextAllFull = (nextCount >= cap) && nextBuf && nextShift;
    wrIdx       = IDX_W'(effCount);
    atLevel     = (count >= level);
    rxIrq       = atLevel && !wasAbove;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      count     <= '0;
      bufFull   <= 1'b0;
      shiftFull <= 1'b0;
      rxEn      <= 1'b0;
      overrun   <= 1'b0;
      wasAbove  <= 1'b0;
    end else begin
      count     <= nextCount;
      bufFull   <= nextBuf;
      shiftFull <= nextShift;
      wasAbove  <= atLevel;
      overrun   <= fifoClr ? 1'b0 : (overrun | drop);
      if (rxEnSet)                        rxEn <= 1'b1;
      else if (stopAtFull && nextAllFull) rxEn <= 1'b0;
    end
  end

  assert_count_bound_R4: assert property (@(posedge clk) disable iff (!rstN)
    count <= CNT_W'(DEPTH));
  assert_shift_behind_buf_R7: assert property (@(posedge clk) disable iff (!rstN)
    shiftFull |-> bufFull);
  assert_irq_single_R6: assert property (@(posedge clk) disable iff (!rstN)
    rxIrq |=> !rxIrq);
  assert_overrun_sticky_R10: assert property (@(posedge clk) disable iff (!rstN)
    overrun && !fifoClr |=> overrun);
  assert_autostop_only_full_R8: assert property (@(posedge clk) disable iff (!rstN)
    rxEn && !rxEnSet |=> rxEn || (bufFull && shiftFull));
  assert_clear_empties_R11: assert property (@(posedge clk) disable iff (!rstN)
    fifoClr |=> count == '0);
  assert_ignore_disabled_R2: assert property (@(posedge clk) disable iff (!rstN)
    !rxEn && !bufFull && !rdStrobe && !fifoClr |=> $stable(count));

endmodule

// File: rtl/rxq_datapath.sv
module rxq_datapath
  import rxq_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned DEPTH  = 4,
  localparam int unsigned IDX_W = $clog2(DEPTH),
  localparam int unsigned ENT_W = DATA_W + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  rxq_strobe_t       stb,
  input  logic [IDX_W-1:0]  wrIdx,
  input  logic [DATA_W-1:0] charData,
  input  logic              charParErr,
  output logic [DATA_W-1:0] rdData,
  output logic              rdParErr
);

  // Entry layout: parity-error bit above the data
  logic [ENT_W-1:0] stage     [DEPTH];
  logic [ENT_W-1:0] stageNext [DEPTH];
  logic [ENT_W-1:0] bufReg, shiftReg, arrival, pushVal;

  assign arrival = {charParErr, charData};
  assign pushVal = stb.pushFromBuf ? bufReg : arrival;

  // Stage 0 is the read end; a pop moves every entry one step toward it
  always_comb begin
    for (int i = 0; i < DEPTH; i++) begin
      stageNext[i] = stage[i];
      if (stb.pop) stageNext[i] = (i == DEPTH - 1) ? '0 : stage[(i + 1) % DEPTH];
      if (stb.push && (wrIdx == IDX_W'(i))) stageNext[i] = pushVal;
      if (stb.clr) stageNext[i] = '0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) stage[i] <= '0;
      bufReg   <= '0;
      shiftReg <= '0;
      rdData   <= '0;
      rdParErr <= 1'b0;
    end else begin
      for (int i = 0; i < DEPTH; i++) stage[i] <= stageNext[i];
      if (stb.bufLoad)   bufReg   <= stb.bufFromShift ? shiftReg : arrival;
      if (stb.shiftLoad) shiftReg <= arrival;
      if (stb.pop)         {rdParErr, rdData} <= stage[0];
      else if (stb.rdZero) {rdParErr, rdData} <= '0;
    end
  end

  assert_empty_read_zero_R5: assert property (@(posedge clk) disable iff (!rstN)
    stb.rdZero && !stb.pop |=> (rdData == '0) && !rdParErr);
  assert_read_holds_R4: assert property (@(posedge clk) disable iff (!rstN)
    !stb.pop && !stb.rdZero |=> $stable(rdData) && $stable(rdParErr));

endmodule

// File: rtl/rx_char_queue.sv
module rx_char_queue
  import rxq_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned DEPTH  = 4,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1),
  localparam int unsigned IDX_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              charValid,
  input  logic [DATA_W-1:0] charData,
  input  logic              charParErr,
  input  logic              rxEnSet,
  input  logic              fifoClr,
  input  logic [IDX_W-1:0]  fillLevel,
  input  logic              limitToLevel,
  input  logic              stopAtFull,
  input  logic              rdStrobe,
  output logic [DATA_W-1:0] rdData,
  output logic              rdParErr,
  output logic [CNT_W-1:0]  fifoCount,
  output logic              bufFull,
  output logic              rxEn,
  output logic              overrun,
  output logic              rxIrq
);

  rxq_strobe_t      stb;
  logic [IDX_W-1:0] wrIdx;

  rxq_ctrl #(.DEPTH(DEPTH)) uCtrl (
    .clk(clk), .rstN(rstN), .charValid(charValid), .rxEnSet(rxEnSet),
    .fifoClr(fifoClr), .rdStrobe(rdStrobe), .limitToLevel(limitToLevel),
    .stopAtFull(stopAtFull), .fillLevel(fillLevel), .stb(stb), .wrIdx(wrIdx),
    .count(fifoCount), .bufFull(bufFull), .rxEn(rxEn), .overrun(overrun),
    .rxIrq(rxIrq)
  );

  rxq_datapath #(.DATA_W(DATA_W), .DEPTH(DEPTH)) uData (
    .clk(clk), .rstN(rstN), .stb(stb), .wrIdx(wrIdx), .charData(charData),
    .charParErr(charParErr), .rdData(rdData), .rdParErr(rdParErr)
  );

endmodule

// File: tb/sim_rx_char_queue.sv
`timescale 1ns/1ps
module sim_rx_char_queue;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic charValid = 1'b0, charParErr = 1'b0, rxEnSet = 1'b0, fifoClr = 1'b0;
  logic limitToLevel = 1'b0, stopAtFull = 1'b0, rdStrobe = 1'b0;
  logic [7:0] charData = '0;
  logic [1:0] fillLevel = 2'd2;
  logic [7:0] rdData;
  logic rdParErr, bufFull, rxEn, overrun, rxIrq;
  logic [2:0] fifoCount;

  int nChecks = 0;
  int nFail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  rx_char_queue u0 (
    .clk(clk), .rstN(rstN), .charValid(charValid), .charData(charData),
    .charParErr(charParErr), .rxEnSet(rxEnSet), .fifoClr(fifoClr),
    .fillLevel(fillLevel), .limitToLevel(limitToLevel), .stopAtFull(stopAtFull),
    .rdStrobe(rdStrobe), .rdData(rdData), .rdParErr(rdParErr),
    .fifoCount(fifoCount), .bufFull(bufFull), .rxEn(rxEn), .overrun(overrun),
    .rxIrq(rxIrq)
  );

  typedef struct packed {
    logic       v;
    logic [7:0] d;
    logic       p;
    logic       rd;
    logic [2:0] cnt;
    logic [7:0] rdD;
    logic       rdP;
    logic       irq;
  } vec_t;

  // fill level 2, full depth, continuous reception
  localparam vec_t VECS [8] = '{
    '{1'b1, 8'hA1, 1'b0, 1'b0, 3'd1, 8'h00, 1'b0, 1'b0},
    '{1'b1, 8'hA2, 1'b1, 1'b0, 3'd2, 8'h00, 1'b0, 1'b1},
    '{1'b0, 8'h00, 1'b0, 1'b1, 3'd1, 8'hA1, 1'b0, 1'b0},
    '{1'b1, 8'hA3, 1'b0, 1'b0, 3'd2, 8'h00, 1'b0, 1'b1},
    '{1'b1, 8'hA4, 1'b1, 1'b1, 3'd2, 8'hA2, 1'b1, 1'b0},
    '{1'b0, 8'h00, 1'b0, 1'b1, 3'd1, 8'hA3, 1'b0, 1'b0},
    '{1'b0, 8'h00, 1'b0, 1'b1, 3'd0, 8'hA4, 1'b1, 1'b0},
    '{1'b0, 8'h00, 1'b0, 1'b1, 3'd0, 8'h00, 1'b0, 1'b0}
  };

  task automatic chk(input string req, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // drive one cycle of stimulus; state is sampled 1 ns after the edge
  task automatic cyc(input logic v, input logic [7:0] d, input logic p, input logic rd);
    charValid = v; charData = d; charParErr = p; rdStrobe = rd;
    @(posedge clk); #1;
    charValid = 1'b0; rdStrobe = 1'b0; rxEnSet = 1'b0; fifoClr = 1'b0;
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      nFail++;
      nChecks++;
      $display("FAIL watchdog: actual hung expected finished");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    // R1 reset state
    chk("R1 count", fifoCount, 0);
    chk("R1 rxEn", rxEn, 0);
    chk("R1 bufFull", bufFull, 0);
    chk("R1 overrun", overrun, 0);
    chk("R1 irq", rxIrq, 0);
    chk("R1 rdData", {rdParErr, rdData}, 0);

    // R2 disabled receiver ignores characters
    cyc(1'b1, 8'h11, 1'b0, 1'b0);
    chk("R2 ignored count", fifoCount, 0);
    rxEnSet = 1'b1;
    cyc(1'b0, 8'h00, 1'b0, 1'b0);
    chk("R2 enable set", rxEn, 1);

    // table walk: R3 direct push, R4 order and parity, R6 pulse
    for (int k = 0; k < 8; k++) begin
      cyc(VECS[k].v, VECS[k].d, VECS[k].p, VECS[k].rd);
      chk($sformatf("R3 count vec %0d", k), fifoCount, VECS[k].cnt);
      chk($sformatf("R3 bufFull vec %0d", k), bufFull, 0);
      chk($sformatf("R6 irq vec %0d", k), rxIrq, VECS[k].irq);
      if (VECS[k].rd) begin
        chk($sformatf("R4 rdData vec %0d", k), rdData, VECS[k].rdD);
        chk($sformatf("R4 rdParErr vec %0d", k), rdParErr, VECS[k].rdP);
      end
    end

    // R6 level code 0 means four entries
    fillLevel = 2'd0;
    for (int k = 0; k < 4; k++) begin
      cyc(1'b1, 8'h41 + 8'(k), 1'(k), 1'b0);
      chk($sformatf("R6 level4 irq push %0d", k), rxIrq, (k == 3) ? 1 : 0);
    end
    cyc(1'b0, 8'h00, 1'b0, 1'b0);
    chk("R6 pulse one cycle", rxIrq, 0);
    cyc(1'b0, 8'h00, 1'b0, 1'b1);
    chk("R6 below level no irq", rxIrq, 0);
    chk("R4 first of four", rdData, 8'h41);
    cyc(1'b1, 8'h45, 1'b0, 1'b0);
    chk("R6 rearmed irq", rxIrq, 1);
    fifoClr = 1'b1;
    cyc(1'b0, 8'h00, 1'b0, 1'b0);
    chk("R11 clear count", fifoCount, 0);

    // R5 empty read
    cyc(1'b0, 8'h00, 1'b0, 1'b1);
    chk("R5 empty data", rdData, 0);
    chk("R5 empty parity", rdParErr, 0);
    chk("R5 empty count", fifoCount, 0);

    // R7/R8 limited depth with automatic stop
    fillLevel = 2'd2; limitToLevel = 1'b1; stopAtFull = 1'b1;
    cyc(1'b1, 8'h51, 1'b0, 1'b0);
    cyc(1'b1, 8'h52, 1'b1, 1'b0);
    chk("R7 count at level", fifoCount, 2);
    cyc(1'b1, 8'h53, 1'b0, 1'b0);
    chk("R7 held in buffer count", fifoCount, 2);
    chk("R7 buffer full", bufFull, 1);
    chk("R8 still enabled", rxEn, 1);
    cyc(1'b1, 8'h54, 1'b1, 1'b0);
    chk("R8 auto stop", rxEn, 0);
    cyc(1'b1, 8'h55, 1'b0, 1'b0);
    chk("R8 no overrun when stopped", overrun, 0);
    cyc(1'b0, 8'h00, 1'b0, 1'b1);
    chk("R9 read B1", rdData, 8'h51);
    chk("R9 refilled count", fifoCount, 2);
    chk("R9 shift moved to buffer", bufFull, 1);
    cyc(1'b0, 8'h00, 1'b0, 1'b1);
    chk("R9 read B2", rdData, 8'h52);
    chk("R9 read B2 parity", rdParErr, 1);
    chk("R9 buffer drained", bufFull, 0);
    cyc(1'b0, 8'h00, 1'b0, 1'b1);
    chk("R9 read B3", rdData, 8'h53);
    cyc(1'b0, 8'h00, 1'b0, 1'b1);
    chk("R9 read B4", rdData, 8'h54);
    cyc(1'b0, 8'h00, 1'b0, 1'b1);
    chk("R8 late char ignored", rdData, 8'h00);

    // R10 overrun in continuous mode, depth one
    stopAtFull = 1'b0; fillLevel = 2'd1;
    rxEnSet = 1'b1;
    cyc(1'b0, 8'h00, 1'b0, 1'b0);
    cyc(1'b1, 8'h61, 1'b0, 1'b0);
    cyc(1'b1, 8'h62, 1'b0, 1'b0);
    cyc(1'b1, 8'h63, 1'b0, 1'b0);
    chk("R10 not yet overrun", overrun, 0);
    cyc(1'b1, 8'h64, 1'b0, 1'b0);
    chk("R10 overrun set", overrun, 1);
    chk("R9 continuous enable kept", rxEn, 1);
    cyc(1'b0, 8'h00, 1'b0, 1'b1);
    chk("R9 read C1", rdData, 8'h61);
    chk("R9 count after C1", fifoCount, 1);
    cyc(1'b0, 8'h00, 1'b0, 1'b1);
    chk("R9 read C2", rdData, 8'h62);
    cyc(1'b0, 8'h00, 1'b0, 1'b1);
    chk("R9 read C3", rdData, 8'h63);
    cyc(1'b0, 8'h00, 1'b0, 1'b1);
    chk("R10 C4 dropped", rdData, 8'h00);
    chk("R10 sticky", overrun, 1);
    fifoClr = 1'b1;
    cyc(1'b0, 8'h00, 1'b0, 1'b0);
    chk("R10 cleared", overrun, 0);

    // R11 clear keeps buffered character
    cyc(1'b1, 8'h71, 1'b0, 1'b0);
    cyc(1'b1, 8'h72, 1'b1, 1'b0);
    chk("R11 buffer loaded", bufFull, 1);
    fifoClr = 1'b1;
    cyc(1'b0, 8'h00, 1'b0, 1'b0);
    chk("R11 queue emptied", fifoCount, 0);
    chk("R11 buffer kept", bufFull, 1);
    cyc(1'b0, 8'h00, 1'b0, 1'b0);
    chk("R11 buffer drained in", fifoCount, 1);
    chk("R11 irq rearmed", rxIrq, 1);
    cyc(1'b0, 8'h00, 1'b0, 1'b1);
    chk("R11 read buffered", rdData, 8'h72);
    chk("R11 read parity", rdParErr, 1);

    done = 1'b1;
    summary();
    $finish;
  end

endmodule